// File: doc/BRIEF.md
# Control-Flow Trace Ring

This block keeps a short history of control transfers (taken branches, interrupts and exceptions). Each accepted event stores a source address and a destination address together in one slot of a circular store. A top-of-stack pointer always names the slot that holds the newest pair. When every slot is full, each new event overwrites the oldest pair.

A small control register gates recording. One bit turns capture on. Two further bits drop events according to the privilege level at which they occur: one bit for user level and one for supervisor level. Privilege 0 counts as supervisor, and privileges 1 to 3 count as user. Software reads the control register, the pointer and any slot through a combinational read port that takes an index.

Events arrive on one port that does not tell the event types apart. The producer presents a branch, an interrupt or an exception in exactly the same way.

Top module: `trace_ring_top`

## Requirements
- R1: While rst_n is low at a clock edge, the pointer, every slot's source and destination, and all three control bits are cleared to zero.
- R2: When ctl_wr_en is high at a clock edge, ctl_wr_data is loaded into the control register and shows on ctl_q after that edge. Bit 0 is the record enable, bit 1 suppresses user-level events and bit 2 suppresses supervisor-level events.
- R3: While the enable bit is 0, a valid event leaves the pointer and every slot unchanged.
- R4: An accepted event moves the pointer to (pointer + 1) modulo DEPTH at the clock edge. It leaves the pointer unchanged when no event is accepted.
- R5: An accepted event writes its source and destination addresses into the slot that the advanced pointer names. No other slot changes.
- R6: After DEPTH further accepted events, the pointer returns to its starting value, and the oldest pair is overwritten by the newest.
- R7: With bit 1 set, an event at privilege 1, 2 or 3 is dropped. The same setting still records a privilege 0 event.
- R8: With bit 2 set, an event at privilege 0 is dropped. The same setting still records a user-level event.
- R9: rd_from and rd_to return the slot selected by rd_idx within the same cycle. An event arriving in that cycle shows on the read port only after the next clock edge.
- R10: When an event and a control write arrive in the same cycle, the event is filtered by the control value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 3 | Control value: bit 0 enable, bit 1 user suppress, bit 2 supervisor suppress |
| ctl_q | output | 3 | Current control register |
| evt_valid | input | 1 | A control-flow event is presented this cycle |
| evt_priv | input | 2 | Privilege level of the event, 0 is supervisor |
| evt_from | input | AW | Source address of the transfer |
| evt_to | input | AW | Destination address of the transfer |
| rd_idx | input | PW | Slot to read |
| rd_from | output | AW | Source address held in the selected slot |
| rd_to | output | AW | Destination address held in the selected slot |
| tos | output | PW | Index of the slot holding the newest pair |

## Verification
The bench drives every input on a falling clock edge. Results fall into two timing groups:
- Events and control writes show on tos, the slots and ctl_q one rising edge later, so the bench checks them on the following falling edge.
- The read port has no register in its path, so the bench checks it 1 ns after it changes rd_idx, within the same cycle.

The same-cycle read case (R9) and the same-cycle control write case (R10) are each checked on both sides of the edge that separates the old value from the new one.

// File: rtl/trace_ring_pkg.sv
// Package: types and constants shared by the trace ring modules.
// Assumes the control register layout {sup_sv, sup_usr, en}, with en at bit 0.
package trace_ring_pkg;

    localparam int CTL_W = 3;

    typedef struct packed {
        logic sup_sv;   // bit 2: drop privilege-0 events
        logic sup_usr;  // bit 1: drop privilege 1..3 events
        logic en;       // bit 0: recording on
    } ring_ctl_t;

    localparam logic [1:0] PRIV_SUPERVISOR = 2'd0;

endpackage

// File: rtl/trace_ring_ctrl.sv
// Module: holds the recording control register.
// Assumes a synchronous active-low reset. A write takes effect after the edge.
module trace_ring_ctrl
    import trace_ring_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [CTL_W-1:0]    wr_data,
    output ring_ctl_t           ctl
);

    // Load the control value on a write and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr_en)
            ctl <= ring_ctl_t'(wr_data);
    end

endmodule

// File: rtl/trace_ring_filter.sv
// Module: decides whether a presented event is recorded.
// Assumes privilege 0 is supervisor and every other level is user.
module trace_ring_filter
    import trace_ring_pkg::*;
(
    input  logic        evt_valid,
    input  logic [1:0]  evt_priv,
    input  ring_ctl_t   ctl,
    output logic        accept
);

    logic is_sv;
    logic blocked;

    // Pick the suppression bit that matches the event's privilege level.
    always_comb begin
        is_sv   = (evt_priv == PRIV_SUPERVISOR);
        blocked = is_sv ? ctl.sup_sv : ctl.sup_usr;
        accept  = evt_valid && ctl.en && !blocked;
    end

endmodule

// File: rtl/trace_ring_store.sv
// Module: circular store of source/destination pairs with a newest-entry pointer.
// Assumes DEPTH >= 2. The pointer advances before the write, so after the
// edge it names the slot that was just written.
module trace_ring_store #(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_from,
    input  logic [AW-1:0]   wr_to,
    input  logic [PW-1:0]   rd_idx,
    output logic [AW-1:0]   rd_from,
    output logic [AW-1:0]   rd_to,
    output logic [PW-1:0]   tos
);

    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] slot_from [DEPTH];
    logic [AW-1:0] slot_to   [DEPTH];
    logic [PW-1:0] nxt;

    // Next pointer value, wrapping at the last slot.
    always_comb begin
        nxt = (tos == LAST) ? '0 : tos + PW'(1);
    end

    // Advance the pointer on every accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tos <= '0;
        else if (wr_en)
            tos <= nxt;
    end

    // One register pair per slot, written only when the pointer moves onto it.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot_from[i] <= '0;
                slot_to[i]   <= '0;
            end else if (wr_en && nxt == PW'(i)) begin
                slot_from[i] <= wr_from;
                slot_to[i]   <= wr_to;
            end
        end
    end

    // Combinational read of the selected slot.
    always_comb begin
        rd_from = slot_from[rd_idx];
        rd_to   = slot_to[rd_idx];
    end

    // R4: the pointer steps by exactly one, with wrap, on an accepted event.
    a_r4_tos_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tos == (($past(tos) == LAST) ? '0 : $past(tos) + PW'(1))));

    // R4: the pointer holds when nothing is accepted.
    a_r4_tos_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tos));

    // R5: the newest slot holds the accepted pair after the edge.
    a_r5_pair_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (slot_from[tos] == $past(wr_from) && slot_to[tos] == $past(wr_to)));

endmodule

// File: rtl/trace_ring_top.sv
// Module: top of the control-flow trace ring. It joins the control register,
// the privilege filter and the circular store.
// Assumes events are filtered by the control value held before any write in
// the same cycle.
module trace_ring_top
    import trace_ring_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctl_wr_en,
    input  logic [CTL_W-1:0]    ctl_wr_data,
    output logic [CTL_W-1:0]    ctl_q,
    input  logic                evt_valid,
    input  logic [1:0]          evt_priv,
    input  logic [AW-1:0]       evt_from,
    input  logic [AW-1:0]       evt_to,
    input  logic [PW-1:0]       rd_idx,
    output logic [AW-1:0]       rd_from,
    output logic [AW-1:0]       rd_to,
    output logic [PW-1:0]       tos
);

    ring_ctl_t ctl;
    logic      accept;

    trace_ring_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_data (ctl_wr_data),
        .ctl     (ctl)
    );

    trace_ring_filter u_filter (
        .evt_valid (evt_valid),
        .evt_priv  (evt_priv),
        .ctl       (ctl),
        .accept    (accept)
    );

    trace_ring_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_from (evt_from),
        .wr_to   (evt_to),
        .rd_idx  (rd_idx),
        .rd_from (rd_from),
        .rd_to   (rd_to),
        .tos     (tos)
    );

    // Bring the control register out.
    always_comb ctl_q = ctl;

    // R2: a control write shows on ctl_q after the edge.
    a_r2_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_wr_en |=> (ctl_q == $past(ctl_wr_data)));

    // R3: with recording off, an event does not move the pointer.
    a_r3_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !ctl_q[0]) |=> $stable(tos));

    // R7: a suppressed user-level event does not move the pointer.
    a_r7_user_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ctl_q[1] && evt_priv != 2'd0) |=> $stable(tos));

    // R8: a suppressed supervisor event does not move the pointer.
    a_r8_sv_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ctl_q[2] && evt_priv == 2'd0) |=> $stable(tos));

endmodule

// File: tb/trace_ring_top_bench.sv
// Directed bench for trace_ring_top. It keeps its own model of the ring.
module trace_ring_top_bench;

    localparam int DEPTH = 16;
    localparam int AW    = 32;
    localparam int PW    = $clog2(DEPTH);

    logic            clk = 1'b0;
    logic            rst_n;
    logic            ctl_wr_en;
    logic [2:0]      ctl_wr_data;
    logic [2:0]      ctl_q;
    logic            evt_valid;
    logic [1:0]      evt_priv;
    logic [AW-1:0]   evt_from;
    logic [AW-1:0]   evt_to;
    logic [PW-1:0]   rd_idx;
    logic [AW-1:0]   rd_from;
    logic [AW-1:0]   rd_to;
    logic [PW-1:0]   tos;

    int n_checks = 0;
    int n_fails  = 0;

    logic [AW-1:0] m_from [DEPTH];
    logic [AW-1:0] m_to   [DEPTH];
    logic [PW-1:0] m_tos;
    logic [2:0]    m_ctl;

    always #2 clk = ~clk;

    trace_ring_top #(.DEPTH(DEPTH), .AW(AW)) u_trace_ring_top (
        .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
        .ctl_q(ctl_q), .evt_valid(evt_valid), .evt_priv(evt_priv),
        .evt_from(evt_from), .evt_to(evt_to), .rd_idx(rd_idx),
        .rd_from(rd_from), .rd_to(rd_to), .tos(tos)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic model_accept(input logic [2:0] c, input logic [1:0] p);
        return c[0] && !((p == 2'd0) ? c[2] : c[1]);
    endfunction

    // Compare pointer, control and every slot with the model.
    task automatic check_all(input string tag);
        chk({tag, " tos"}, 64'(tos), 64'(m_tos));
        chk({tag, " ctl"}, 64'(ctl_q), 64'(m_ctl));
        for (int i = 0; i < DEPTH; i++) begin
            rd_idx = PW'(i);
            #1;
            chk({tag, " from"}, 64'(rd_from), 64'(m_from[i]));
            chk({tag, " to"}, 64'(rd_to), 64'(m_to[i]));
        end
    endtask

    task automatic model_event(input logic [1:0] p, input logic [AW-1:0] f, input logic [AW-1:0] t);
        if (model_accept(m_ctl, p)) begin
            m_tos = (m_tos == PW'(DEPTH - 1)) ? '0 : m_tos + PW'(1);
            m_from[m_tos] = f;
            m_to[m_tos]   = t;
        end
    endtask

    // Present one event for one cycle and update the model.
    task automatic send_evt(input logic [1:0] p, input logic [AW-1:0] f, input logic [AW-1:0] t);
        @(negedge clk);
        evt_valid = 1'b1; evt_priv = p; evt_from = f; evt_to = t;
        @(negedge clk);
        evt_valid = 1'b0;
        model_event(p, f, t);
    endtask

    task automatic write_ctl(input logic [2:0] d);
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = d;
        @(negedge clk);
        ctl_wr_en = 1'b0;
        m_ctl = d;
        chk("R2 ctl write", 64'(ctl_q), 64'(d));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_tos = '0; m_ctl = '0;
        for (int i = 0; i < DEPTH; i++) begin m_from[i] = '0; m_to[i] = '0; end
        check_all("R1 reset");
    endtask

    task automatic t_disabled();    // R3
        write_ctl(3'b000);
        send_evt(2'd0, 32'hDEAD0001, 32'hBEEF0001);
        send_evt(2'd3, 32'hDEAD0002, 32'hBEEF0002);
        check_all("R3 disabled");
    endtask

    task automatic t_basic();       // R4 R5
        write_ctl(3'b001);
        send_evt(2'd0, 32'h1000_0000, 32'h2000_0000);
        chk("R4 tos step", 64'(tos), 64'd1);
        send_evt(2'd3, 32'h1000_0010, 32'h2000_0010);
        send_evt(2'd1, 32'h1000_0020, 32'h2000_0020);
        chk("R4 tos step", 64'(tos), 64'd3);
        check_all("R5 pairs");
    endtask

    task automatic t_wrap();        // R6
        logic [PW-1:0] start;
        start = m_tos;
        for (int i = 0; i < DEPTH; i++)
            send_evt(2'(i), 32'hA000_0000 + 32'(i), 32'hB000_0000 + 32'(i));
        chk("R6 wrap tos", 64'(tos), 64'(start));
        rd_idx = start; #1;
        chk("R6 oldest overwritten", 64'(rd_from), 64'hA000_000F);
        check_all("R6 wrap");
    endtask

    task automatic t_user_sup();    // R7
        write_ctl(3'b011);
        send_evt(2'd1, 32'h0000_7001, 32'h0000_8001);
        send_evt(2'd3, 32'h0000_7003, 32'h0000_8003);
        send_evt(2'd0, 32'h0000_7000, 32'h0000_8000);
        check_all("R7 user suppress");
    endtask

    task automatic t_sv_sup();      // R8
        write_ctl(3'b101);
        send_evt(2'd0, 32'h0000_9000, 32'h0000_A000);
        send_evt(2'd2, 32'h0000_9002, 32'h0000_A002);
        check_all("R8 sv suppress");
    endtask

    task automatic t_same_cycle_read();  // R9
        logic [PW-1:0] slot;
        write_ctl(3'b001);
        slot = (m_tos == PW'(DEPTH - 1)) ? '0 : m_tos + PW'(1);
        @(negedge clk);
        rd_idx = slot;
        evt_valid = 1'b1; evt_priv = 2'd2; evt_from = 32'hC0DE_0001; evt_to = 32'hC0DE_0002;
        #1;
        chk("R9 old value in cycle", 64'(rd_from), 64'(m_from[slot]));
        @(negedge clk);
        evt_valid = 1'b0;
        model_event(2'd2, 32'hC0DE_0001, 32'hC0DE_0002);
        rd_idx = slot; #1;
        chk("R9 new value after edge", 64'(rd_to), 64'h0000_0000_C0DE_0002);
    endtask

    task automatic t_ctl_race();    // R10
        // Enabled now, with a disable written in the same cycle: the event is kept.
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = 3'b000;
        evt_valid = 1'b1; evt_priv = 2'd0; evt_from = 32'hE000_0001; evt_to = 32'hE000_0002;
        @(negedge clk);
        ctl_wr_en = 1'b0; evt_valid = 1'b0;
        model_event(2'd0, 32'hE000_0001, 32'hE000_0002);
        m_ctl = 3'b000;
        check_all("R10 old ctl keeps");
        // Disabled now, with an enable written in the same cycle: the event is dropped.
        @(negedge clk);
        ctl_wr_en = 1'b1; ctl_wr_data = 3'b001;
        evt_valid = 1'b1; evt_priv = 2'd1; evt_from = 32'hE000_0003; evt_to = 32'hE000_0004;
        @(negedge clk);
        ctl_wr_en = 1'b0; evt_valid = 1'b0;
        model_event(2'd1, 32'hE000_0003, 32'hE000_0004);
        m_ctl = 3'b001;
        check_all("R10 old ctl drops");
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = '0;
        evt_valid = 1'b0; evt_priv = '0; evt_from = '0; evt_to = '0; rd_idx = '0;
        do_reset();
        t_disabled();
        t_basic();
        t_wrap();
        t_user_sup();
        t_sv_sup();
        t_same_cycle_read();
        t_ctl_race();
        write_ctl(3'b111);
        do_reset();     // R1: non-zero slots and control cleared again
        finish_run();
    end

endmodule